// File: doc/BRIEF.md
# Sequential BCD-to-Binary Converter

This block turns a packed BCD number into straight binary. It works over several clock cycles instead of using a wide lookup table. A single working register holds the BCD decades on its upper side and a binary field on its lower side. On each step the whole register moves right by one bit. The bit that leaves the lowest decade enters the binary field from its top end. After the move, any decade that now holds more than seven has three taken off it. Once every input bit has been moved out, the BCD side is empty and the binary field holds the value.

A caller places the BCD word on `bcd_in` and raises `start` for one cycle. The block first checks the decades. If any decade used by the selected mode is above nine, the block does not convert. It gives a one-cycle `err` pulse and leaves the last result in place. For a legal input, `busy` stays high for one cycle per input bit. A one-cycle `done` pulse then marks the cycle in which `bin_out` first shows the new result. The narrow mode keeps only the low digit and the two low bits of the tens digit, so its range is 0 to 39. A separate `inhibit` input forces every bit of `bin_out` to one. It does this at once and does not disturb the conversion underneath.

The control is a two-state machine. ST_IDLE waits for `start`. The transition ST_IDLE→ST_SHIFT is taken on a start with a legal input. The transition ST_IDLE→ST_IDLE with an error pulse is taken on a start with an illegal input. ST_SHIFT performs one shift and correction per cycle. The transition ST_SHIFT→ST_IDLE is taken after the last step and raises `done`. While the machine is in ST_SHIFT, `start` is ignored.

Top module: `bcd2bin_seq`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low, and `bin_out` reads 0 while `inhibit` is low.
- R2: With `narrow` low, a legal input whose tens digit is `bcd_in[7:4]` and whose units digit is `bcd_in[3:0]` yields `bin_out` = tens×10 + units, for every value from 0 to 99.
- R3: Suppose `start` is sampled high at clock edge k with a legal input. Then `busy` is high from edge k to edge k+8, that is 8 cycles, one per input bit. `done` is high for exactly the one cycle after edge k+8, and `busy` is low in that cycle.
- R4: Each step shifts the combined decade/binary register right by one bit, and the bit leaving the low decade enters the top of the binary field. Any decade above 7 after the shift is reduced by 3. No decade ever holds more than 9, and the decade side is all zero after the final step.
- R5: `bin_out[0]` equals bit 0 of the units digit of the converted input.
- R6: With `narrow` high, `bcd_in[7:6]` is ignored and the result is `bcd_in[5:4]`×10 + `bcd_in[3:0]`, which lies in the range 0 to 39.
- R7: While `inhibit` is high, every bit of `bin_out` is 1 whatever the input or state. When `inhibit` drops, `bin_out` shows the stored result again.
- R8: A start whose used decades include a value above 9 sets `err` high for exactly one cycle after the sampling edge. In that case `busy` and `done` stay low and `bin_out` keeps its previous value.
- R9: A `start` that arrives while `busy` is high is ignored. The running conversion keeps its original input and its original timing.
- R10: `bin_out` holds the last result until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to load `bcd_in` and convert |
| narrow | input | 1 | Selects the 0 to 39 mode (two tens bits only) |
| inhibit | input | 1 | Forces `bin_out` to all ones |
| bcd_in | input | 8 | Packed BCD input, units digit in bits 3:0 |
| busy | output | 1 | High while conversion steps run |
| done | output | 1 | One-cycle pulse when a new result appears |
| err | output | 1 | One-cycle pulse on an illegal decade |
| bin_out | output | 7 | Binary result |

## Verification
The hardest case to reach from the ports is a second `start` that lands in the middle of a running conversion. It must change neither the captured value nor the length of the busy window. The stimulus creates this case on purpose: it raises `start` with a different, legal value during the third busy cycle and then checks both the timing and the first value's result. Narrow-mode inputs carry random junk in the two ignored tens bits, so that any leak of those bits shows up. All hundred two-decade values are converted exhaustively.

// File: rtl/bcd2bin_pkg.sv
package bcd2bin_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } cvt_state_t;
endpackage

// File: rtl/bcd2bin_digit_fix.sv
// One decade correction: a value above seven loses three.
module bcd2bin_digit_fix (
    input  logic [3:0] din,
    output logic [3:0] dout
);
    always_comb begin
        if (din > 4'd7) dout = din - 4'd3;
        else            dout = din;
    end
endmodule

// File: rtl/bcd2bin_legal.sv
// Flags whether every decade of a packed BCD word is at most nine.
module bcd2bin_legal #(
    parameter int DECADES = 2
) (
    input  logic [4*DECADES-1:0] word,
    output logic                 ok
);
    logic [DECADES-1:0] dig_ok;

    for (genvar d = 0; d < DECADES; d++) begin : g_chk
        assign dig_ok[d] = (word[4*d +: 4] <= 4'd9);
    end

    assign ok = &dig_ok;
endmodule

// File: rtl/bcd2bin_step.sv
// One iteration: shift the decade/binary pair right, then correct each decade.
module bcd2bin_step #(
    parameter int DECADES = 2,
    parameter int BW      = 8
) (
    input  logic [4*DECADES-1:0] dec_i,
    input  logic [BW-1:0]        bin_i,
    output logic [4*DECADES-1:0] dec_o,
    output logic [BW-1:0]        bin_o
);
    localparam int W = 4 * DECADES;

    logic [W-1:0] shifted;

    assign shifted = dec_i >> 1;
    assign bin_o   = {dec_i[0], bin_i[BW-1:1]};

    for (genvar d = 0; d < DECADES; d++) begin : g_fix
        bcd2bin_digit_fix u_fix (
            .din  (shifted[4*d +: 4]),
            .dout (dec_o[4*d +: 4])
        );
    end
endmodule

// File: rtl/bcd2bin_seq.sv
module bcd2bin_seq
    import bcd2bin_pkg::*;
#(
    parameter int DECADES = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic                                 narrow,
    input  logic                                 inhibit,
    input  logic [4*DECADES-1:0]                 bcd_in,
    output logic                                 busy,
    output logic                                 done,
    output logic                                 err,
    output logic [$clog2(10**DECADES)-1:0]       bin_out
);
    localparam int W           = 4 * DECADES;
    localparam int BIN_W       = $clog2(10**DECADES);
    localparam int CNT_W       = $clog2(W + 1);
    localparam int NARROW_BITS = 6;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);
    localparam logic [W-1:0] NARROW_MASK =
        {{(W-NARROW_BITS){1'b0}}, {NARROW_BITS{1'b1}}};

    cvt_state_t         state_q, state_d;
    logic [W-1:0]       dec_q, dec_nx, in_masked;
    logic [W-1:0]       bin_q, bin_nx;
    logic [CNT_W-1:0]   cnt_q;
    logic [BIN_W-1:0]   res_q;
    logic               lsb_q, in_ok;

    assign in_masked = narrow ? (bcd_in & NARROW_MASK) : bcd_in;

    bcd2bin_legal #(.DECADES(DECADES)) u_legal (
        .word (in_masked),
        .ok   (in_ok)
    );

    bcd2bin_step #(.DECADES(DECADES), .BW(W)) u_step (
        .dec_i (dec_q),
        .bin_i (bin_q),
        .dec_o (dec_nx),
        .bin_o (bin_nx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start && in_ok) state_d = ST_SHIFT;
            ST_SHIFT: if (cnt_q == LAST)  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
            bin_q <= '0;
            cnt_q <= '0;
            res_q <= '0;
            lsb_q <= 1'b0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (in_ok) begin
                            dec_q <= in_masked;
                            bin_q <= '0;
                            cnt_q <= '0;
                            lsb_q <= in_masked[0];
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                ST_SHIFT: begin
                    dec_q <= dec_nx;
                    bin_q <= bin_nx;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        res_q <= bin_nx[BIN_W-1:0];
                        done  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy    = (state_q == ST_SHIFT);
    assign bin_out = inhibit ? {BIN_W{1'b1}} : res_q;

    // Assertions
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != LAST) |=> busy);

    assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));

    assert_decades_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == LAST) |-> (dec_nx == '0));

    for (genvar d = 0; d < DECADES; d++) begin : g_rng
        assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
            busy |-> (dec_nx[4*d +: 4] <= 4'd9));
    end

    assert_lsb_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_q[0] == lsb_q));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(lsb_q));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(res_q));
endmodule

// File: tb/tb_bcd2bin_seq.sv
module tb_bcd2bin_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       narrow = 1'b0;
    logic       inhibit = 1'b0;
    logic [7:0] bcd_in = 8'h00;
    logic       busy, done, err;
    logic [6:0] bin_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [6:0] last_res = 7'd0;

    always #2 clk = ~clk;

    bcd2bin_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .narrow(narrow),
        .inhibit(inhibit), .bcd_in(bcd_in), .busy(busy), .done(done),
        .err(err), .bin_out(bin_out)
    );

    function automatic int expect_val(input logic [7:0] v, input bit nar);
        if (nar) return int'(v[5:4]) * 10 + int'(v[3:0]);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] v, input bit nar, input bit inh,
                       input bit inject, input string req);
        int exp_v;
        bit timing_ok;
        exp_v = expect_val(v, nar);
        timing_ok = 1'b1;
        @(negedge clk);
        bcd_in = v; narrow = nar; inhibit = inh; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (!(busy && !done)) timing_ok = 1'b0;
            if (inject && i == 2) begin start = 1'b1; bcd_in = 8'h57; narrow = 1'b0; end
            if (inject && i == 3) start = 1'b0;
            @(negedge clk);
        end
        chk(timing_ok, "R3 busy window", int'(timing_ok), 1);
        chk(done && !busy, "R3 done after busy", int'(done), 1);
        if (inh) begin
            chk(bin_out == 7'h7F, "R7 inhibit during conversion", bin_out, 127);
            inhibit = 1'b0;
            #1;
        end
        chk(bin_out == 7'(exp_v), req, bin_out, exp_v);
        chk(bin_out[0] == v[0], "R5 lsb passthrough", bin_out[0], v[0]);
        @(negedge clk);
        chk(!done && !busy, "R3 done one cycle", int'(done), 0);
        chk(bin_out == 7'(exp_v), "R10 result held", bin_out, exp_v);
        last_res = 7'(exp_v);
    endtask

    task automatic run_err(input logic [7:0] v, input bit nar);
        @(negedge clk);
        bcd_in = v; narrow = nar; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err && !busy && !done, "R8 error pulse", int'(err), 1);
        @(negedge clk);
        chk(!err && !busy && !done, "R8 error one cycle", int'(err), 0);
        chk(bin_out == last_res, "R8 result untouched", bin_out, last_res);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err, "R1 reset flags", int'(busy | done | err), 0);
        chk(bin_out == 7'd0, "R1 reset result", bin_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && bin_out == 0, "R1 idle after reset", bin_out, 0);

        // R2: every legal two-decade value
        for (int t = 0; t < 10; t++)
            for (int u = 0; u < 10; u++)
                run({4'(t), 4'(u)}, 1'b0, 1'b0, 1'b0, "R2 two-decade value");

        // R6: narrow mode, ignored bits random, plus directed corner
        run(8'hF9, 1'b1, 1'b0, 1'b0, "R6 narrow 39 upper bits set");
        run(8'h00, 1'b1, 1'b0, 1'b0, "R6 narrow zero");
        for (int k = 0; k < 40; k++) begin
            logic [7:0] v;
            v = {2'($urandom_range(3)), 2'($urandom_range(3)), 4'($urandom_range(9))};
            run(v, 1'b1, 1'b0, 1'b0, "R6 narrow random");
        end

        // R9: start during busy is ignored
        run(8'h42, 1'b0, 1'b0, 1'b1, "R9 start ignored while busy");

        // R7: inhibit when idle, then during a conversion
        @(negedge clk);
        inhibit = 1'b1;
        #1;
        chk(bin_out == 7'h7F, "R7 inhibit idle", bin_out, 127);
        inhibit = 1'b0;
        #1;
        chk(bin_out == last_res, "R7 release restores", bin_out, last_res);
        run(8'h86, 1'b0, 1'b1, 1'b0, "R7 result after inhibit");

        // R8: illegal decades
        run_err(8'h3C, 1'b0);
        run_err(8'hA1, 1'b0);
        run_err(8'hCB, 1'b1);
        run(8'h99, 1'b0, 1'b0, 1'b0, "R2 recovery after error");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule